// File: doc/BRIEF.md
# Byte Access Sequencer for a Dual-Line Resistive Memory Array

This block is the digital sequencer in front of a byte-wide conductive-bridge memory array in which every column has two lines: an anode line and a source line. A requester hands it one operation at a time: read, program or erase, together with an address and a data byte. The block then runs the operation cycle by cycle. It raises the word line at the right voltage level, points the column multiplexers at the addressed byte, and either drives the per-bit line enables or runs the sense strobe. When the operation is over it reports completion.

For program and erase, the data byte acts as a per-bit target mask. Only bits set to one receive drive. The other lines in the byte stay grounded. An optional completion input per bit, from the analog side, removes drive from a bit as soon as that cell has switched. The write then ends once every targeted bit has switched, or when the programmable pulse counter runs out, whichever comes first. A read holds the strobe high for a fixed number of cycles with a selectable pull-up strength, and captures the comparator outputs as the strobe falls.

Top module: `rram_byte_seq`

## Requirements
- R1: While `busy` is low, `anode_en`, `source_en`, `wl_en`, `col_sel`, `rd_strobe` and `pullup_code` are all zero.
- R2: Op code 1 (program) drives `anode_en` with the mask byte `req_data` (bit i driven when bit i is 1). `source_en` stays zero and `wl_lvl` is 2 (reduced level) throughout the write cycles.
- R3: Op code 2 (erase) drives `source_en` with the mask byte. `anode_en` stays zero and `wl_lvl` is 3 (raised level) throughout the write cycles.
- R4: When `wr_done_i[i]` is high during a write cycle, bit i receives no drive from the next cycle on. The write ends after the first cycle in which every targeted bit shows completion, and `timeout` is then 0.
- R5: Op code 0 (read) holds `rd_strobe` high for RD_CYC cycles, with `wl_lvl` 1, `col_sel` equal to `req_addr[2:0]` and `wl_row` equal to the upper address bits. `rd_data` takes `sense_i` at the clock edge where the strobe falls, and holds that value afterwards.
- R6: `pullup_code` equals `cfg_pullup` as sampled at acceptance while the strobe is high, and is zero otherwise.
- R7: If no completion arrives, a write drives for exactly the pulse count sampled at acceptance: `cfg_prog_cycles` for program, `cfg_erase_cycles` for erase, with 0 counted as 1. `timeout` is then 1 and stays 1 until the next accepted request.
- R8: Every operation ends with one finish cycle. In that cycle `done` is 1, all line enables are zero (source lines back at ground) and `wl_en` is 0.
- R9: A request is accepted only when idle with an op code other than 3. `busy` is high from the cycle after acceptance through the finish cycle. Requests made while busy, and op code 3, have no effect.
- R10: A write whose mask is zero drives no line, lasts one write cycle and finishes with `timeout` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| req_addr | input | ADDR_W | Byte address: low 3 bits column, rest row |
| req_data | input | 8 | Per-bit target mask for writes |
| cfg_pullup | input | PU_W | Sense pull-up strength setting |
| cfg_prog_cycles | input | CNT_W | Program pulse length in cycles |
| cfg_erase_cycles | input | CNT_W | Erase pulse length in cycles |
| wr_done_i | input | 8 | Per-bit switch-complete indications |
| sense_i | input | 8 | Sense comparator outputs |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| timeout | output | 1 | Last write ended by counter expiry |
| rd_data | output | 8 | Latched read byte |
| wl_en | output | 1 | Word line enable |
| wl_row | output | ADDR_W-3 | Word line row select |
| wl_lvl | output | 2 | Word line level: 0 off, 1 read, 2 program, 3 erase |
| col_sel | output | 3 | 8:1 column multiplexer select |
| anode_en | output | 8 | Per-bit anode line drive |
| source_en | output | 8 | Per-bit source line drive |
| pullup_code | output | PU_W | Pull-up strength applied to sense nodes |
| rd_strobe | output | 1 | Read strobe |

## Verification
The hardest state to reach is a write in which the targeted bits finish at different times. Here each bit's drive has to drop on its own cycle, while the operation ends either on the last completion or on counter expiry. The bench gets there with a behavioural cell model. Each bit gets its own switching delay, counted in the cycles its line was actually driven, and the model raises that bit's completion input once the delay is met. This yields staggered drop-off with no timeout, a mix of switched and stuck bits ending in timeout, and a case where the last completion and the counter limit fall in the same cycle.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } st_e;

    typedef enum logic [1:0] {
        LVL_OFF   = 2'd0,
        LVL_READ  = 2'd1,
        LVL_PROG  = 2'd2,
        LVL_ERASE = 2'd3
    } wl_lvl_e;

    typedef struct packed {
        logic [BYTE_W-1:0] anode;
        logic [BYTE_W-1:0] source;
    } line_drive_t;

    function automatic wl_lvl_e level_for(input op_e op);
        case (op)
            OP_PROG:  return LVL_PROG;
            OP_ERASE: return LVL_ERASE;
            default:  return LVL_READ;
        endcase
    endfunction

endpackage

// File: rtl/rbs_pulse_timer.sv
module rbs_pulse_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] limit_in,
    output logic             last
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lim <= '0;
        end else if (start) begin
            cnt <= '0;
            lim <= limit_in;
        end else if (run && !last) begin
            cnt <= cnt + 1'b1;
        end
    end

    // limit of zero behaves as one cycle
    assign last = ({1'b0, cnt} + 1'b1) >= {1'b0, lim};
endmodule

// File: rtl/rbs_bit_tracker.sv
module rbs_bit_tracker #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic [W-1:0] cmpl,
    output logic [W-1:0] pend,
    output logic         all_clear
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (load) begin
            pend <= load_val;
        end else if (run) begin
            pend <= pend & ~cmpl;
        end
    end

    assign all_clear = ((pend & ~cmpl) == '0);
endmodule

// File: rtl/rram_byte_seq.sv
module rram_byte_seq
    import rbs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int CNT_W  = 8,
    parameter int PU_W   = 2,
    parameter int RD_CYC = 2,
    parameter int MUX    = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [1:0]                    req_op,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [BYTE_W-1:0]             req_data,
    input  logic [PU_W-1:0]               cfg_pullup,
    input  logic [CNT_W-1:0]              cfg_prog_cycles,
    input  logic [CNT_W-1:0]              cfg_erase_cycles,
    input  logic [BYTE_W-1:0]             wr_done_i,
    input  logic [BYTE_W-1:0]             sense_i,
    output logic                          busy,
    output logic                          done,
    output logic                          timeout,
    output logic [BYTE_W-1:0]             rd_data,
    output logic                          wl_en,
    output logic [ADDR_W-$clog2(MUX)-1:0] wl_row,
    output logic [1:0]                    wl_lvl,
    output logic [$clog2(MUX)-1:0]        col_sel,
    output logic [BYTE_W-1:0]             anode_en,
    output logic [BYTE_W-1:0]             source_en,
    output logic [PU_W-1:0]               pullup_code,
    output logic                          rd_strobe
);
    localparam int COL_W = $clog2(MUX);
    localparam logic [CNT_W-1:0] RD_LIM = CNT_W'(RD_CYC);

    st_e               st;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [PU_W-1:0]   pu_q;
    logic              timeout_q;
    logic [BYTE_W-1:0] rd_q;

    logic              accept;
    logic              active;
    logic              last;
    logic              all_clear;
    logic              wr_end;
    logic [BYTE_W-1:0] pend;
    logic [CNT_W-1:0]  lim_sel;
    line_drive_t       drv;

    assign accept = (st == ST_IDLE) && req_valid && (op_e'(req_op) != OP_RSVD);
    assign active = (st == ST_READ) || (st == ST_WRITE);

    always_comb begin
        case (op_e'(req_op))
            OP_PROG:  lim_sel = cfg_prog_cycles;
            OP_ERASE: lim_sel = cfg_erase_cycles;
            default:  lim_sel = RD_LIM;
        endcase
    end

    rbs_pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .run      (active),
        .limit_in (lim_sel),
        .last     (last)
    );

    rbs_bit_tracker #(.W(BYTE_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_val  ((op_e'(req_op) == OP_READ) ? '0 : req_data),
        .run       (st == ST_WRITE),
        .cmpl      (wr_done_i),
        .pend      (pend),
        .all_clear (all_clear)
    );

    assign wr_end = (st == ST_WRITE) && (all_clear || last);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            op_q      <= OP_READ;
            addr_q    <= '0;
            pu_q      <= '0;
            timeout_q <= 1'b0;
            rd_q      <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    st        <= (op_e'(req_op) == OP_READ) ? ST_READ : ST_WRITE;
                    op_q      <= op_e'(req_op);
                    addr_q    <= req_addr;
                    pu_q      <= cfg_pullup;
                    timeout_q <= 1'b0;
                end
                ST_READ: if (last) begin
                    st   <= ST_FINISH;
                    rd_q <= sense_i;
                end
                ST_WRITE: if (wr_end) begin
                    st        <= ST_FINISH;
                    timeout_q <= !all_clear;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // per-column drive: polarity picked by the operation, gated per bit
    for (genvar b = 0; b < BYTE_W; b++) begin : g_col
        assign drv.anode[b]  = (st == ST_WRITE) && (op_q == OP_PROG)  && pend[b];
        assign drv.source[b] = (st == ST_WRITE) && (op_q == OP_ERASE) && pend[b];
    end

    assign anode_en    = drv.anode;
    assign source_en   = drv.source;
    assign busy        = (st != ST_IDLE);
    assign done        = (st == ST_FINISH);
    assign timeout     = timeout_q;
    assign rd_data     = rd_q;
    assign wl_en       = active;
    assign wl_row      = addr_q[ADDR_W-1:COL_W];
    assign wl_lvl      = active ? level_for(op_q) : LVL_OFF;
    assign col_sel     = active ? addr_q[COL_W-1:0] : '0;
    assign rd_strobe   = (st == ST_READ);
    assign pullup_code = (st == ST_READ) ? pu_q : '0;
endmodule

// File: rtl/rbs_seq_checker.sv
module rbs_seq_checker #(
    parameter int PU_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            done,
    input logic            wl_en,
    input logic [1:0]      wl_lvl,
    input logic [7:0]      anode_en,
    input logic [7:0]      source_en,
    input logic [PU_W-1:0] pullup_code,
    input logic            rd_strobe
);
    p_idle_iso_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (anode_en == 8'h0 && source_en == 8'h0 && !wl_en && pullup_code == '0));

    p_prog_pol_r2: assert property (@(posedge clk) disable iff (rst)
        anode_en != 8'h0 |-> (source_en == 8'h0 && wl_lvl == 2'd2));

    p_erase_pol_r3: assert property (@(posedge clk) disable iff (rst)
        source_en != 8'h0 |-> (anode_en == 8'h0 && wl_lvl == 2'd3));

    p_no_redrive_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ((anode_en & ~$past(anode_en)) == 8'h0 &&
                                   (source_en & ~$past(source_en)) == 8'h0));

    p_read_lvl_r5: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |-> (wl_lvl == 2'd1 && anode_en == 8'h0 && source_en == 8'h0));

    p_strobe_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_strobe) |-> (done && !wl_en));

    p_finish_gnd_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (anode_en == 8'h0 && source_en == 8'h0 && !wl_en));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
endmodule

bind rram_byte_seq rbs_seq_checker #(.PU_W(PU_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .wl_en       (wl_en),
    .wl_lvl      (wl_lvl),
    .anode_en    (anode_en),
    .source_en   (source_en),
    .pullup_code (pullup_code),
    .rd_strobe   (rd_strobe)
);

// File: tb/rram_byte_seq_bench.sv
module rram_byte_seq_bench;
    localparam int ADDR_W = 13;
    localparam int CNT_W  = 8;
    localparam int PU_W   = 2;
    localparam int RD_CYC = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_data = 8'h0;
    logic [PU_W-1:0]   cfg_pullup = '0;
    logic [CNT_W-1:0]  cfg_prog_cycles = 8'd3;
    logic [CNT_W-1:0]  cfg_erase_cycles = 8'd5;
    logic [7:0]        wr_done_i;
    logic [7:0]        sense_i = 8'h0;
    logic              busy, done, timeout, wl_en, rd_strobe;
    logic [7:0]        rd_data, anode_en, source_en;
    logic [ADDR_W-4:0] wl_row;
    logic [1:0]        wl_lvl;
    logic [2:0]        col_sel;
    logic [PU_W-1:0]   pullup_code;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    rram_byte_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PU_W(PU_W), .RD_CYC(RD_CYC)) u_rram_byte_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .cfg_pullup(cfg_pullup), .cfg_prog_cycles(cfg_prog_cycles),
        .cfg_erase_cycles(cfg_erase_cycles), .wr_done_i(wr_done_i), .sense_i(sense_i),
        .busy(busy), .done(done), .timeout(timeout), .rd_data(rd_data), .wl_en(wl_en),
        .wl_row(wl_row), .wl_lvl(wl_lvl), .col_sel(col_sel), .anode_en(anode_en),
        .source_en(source_en), .pullup_code(pullup_code), .rd_strobe(rd_strobe)
    );

    // behavioural cells: bit i switches after need[i] driven cycles (0 = never)
    int need [8];
    int drv_cnt [8];
    always @(posedge clk) begin
        for (int i = 0; i < 8; i++) begin
            if (!busy) drv_cnt[i] <= 0;
            else if (anode_en[i] || source_en[i]) drv_cnt[i] <= drv_cnt[i] + 1;
        end
    end
    always_comb begin
        for (int i = 0; i < 8; i++)
            wr_done_i[i] = (need[i] != 0) && (drv_cnt[i] >= need[i]);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // observations of one operation
    int a_cyc [8];
    int s_cyc [8];
    int busy_n, strobe_n, lvl_bad, col_bad, row_bad, pu_bad, fin_bad, inject_cyc;
    logic [1:0] exp_lvl;

    task automatic set_need(input int n0, n1, n2, n3, n4, n5, n6, n7);
        need[0] = n0; need[1] = n1; need[2] = n2; need[3] = n3;
        need[4] = n4; need[5] = n5; need[6] = n6; need[7] = n7;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [ADDR_W-1:0] addr, input logic [7:0] data);
        int cyc;
        for (int i = 0; i < 8; i++) begin a_cyc[i] = 0; s_cyc[i] = 0; end
        busy_n = 0; strobe_n = 0; lvl_bad = 0; col_bad = 0; row_bad = 0; pu_bad = 0; fin_bad = 0;
        exp_lvl = (op == 2'd1) ? 2'd2 : (op == 2'd2) ? 2'd3 : 2'd1;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (cyc < 300) begin
            if (busy) busy_n++;
            if (rd_strobe) begin
                strobe_n++;
                if (pullup_code != cfg_pullup) pu_bad++;
            end else if (pullup_code != '0) pu_bad++;
            if (wl_en) begin
                if (wl_lvl != exp_lvl) lvl_bad++;
                if (col_sel != addr[2:0]) col_bad++;
                if (wl_row != addr[ADDR_W-1:3]) row_bad++;
            end
            for (int i = 0; i < 8; i++) begin
                if (anode_en[i]) a_cyc[i]++;
                if (source_en[i]) s_cyc[i]++;
            end
            if (done) begin
                if (anode_en != 0 || source_en != 0 || wl_en) fin_bad++;
                break;
            end
            cyc++;
            if (cyc == inject_cyc) begin
                req_valid = 1'b1; req_op = 2'd2; req_data = 8'hFF;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!busy && !done && !timeout, "R1 reset busy/done/timeout", {busy, done, timeout}, 0);
        chk(anode_en == 0 && source_en == 0 && !wl_en && col_sel == 0 && !rd_strobe && pullup_code == 0,
            "R1 reset lines grounded", {anode_en, source_en}, 0);
    endtask

    task automatic t_read;
        sense_i = 8'h5A; cfg_pullup = 2'd2;
        run_op(2'd0, 13'h1ABD, 8'h00);
        chk(strobe_n == RD_CYC, "R5 strobe length", strobe_n, RD_CYC);
        chk(lvl_bad == 0 && col_bad == 0 && row_bad == 0, "R5 read level/column/row", lvl_bad + col_bad + row_bad, 0);
        chk(rd_data == 8'h5A, "R5 latched byte", rd_data, 8'h5A);
        chk(pu_bad == 0, "R6 pull-up code during strobe", pu_bad, 0);
        chk(fin_bad == 0 && busy_n == RD_CYC + 1, "R8 read finish", busy_n, RD_CYC + 1);
        sense_i = 8'hC3;
        @(negedge clk);
        chk(rd_data == 8'h5A, "R5 hold after strobe fell", rd_data, 8'h5A);
        sense_i = 8'h3C; cfg_pullup = 2'd1;
        run_op(2'd0, 13'h0002, 8'h00);
        chk(rd_data == 8'h3C && pu_bad == 0 && col_bad == 0, "R6 second strength read", rd_data, 8'h3C);
    endtask

    task automatic t_prog_timeout;
        set_need(0, 0, 0, 0, 0, 0, 0, 0);
        cfg_prog_cycles = 8'd4;
        run_op(2'd1, 13'h0105, 8'hC3);
        for (int i = 0; i < 8; i++)
            chk(a_cyc[i] == ((8'hC3 >> i) & 1) * 4 && s_cyc[i] == 0, "R2 program drive per bit", a_cyc[i], ((8'hC3 >> i) & 1) * 4);
        chk(lvl_bad == 0 && col_bad == 0, "R2 program level", lvl_bad, 0);
        chk(timeout == 1'b1, "R7 timeout on expiry", timeout, 1);
        chk(busy_n == 5 && fin_bad == 0, "R8 program finish", busy_n, 5);
        @(negedge clk);
        chk(timeout == 1'b1 && !busy, "R7 timeout held", timeout, 1);
    endtask

    task automatic t_prog_early;
        set_need(1, 2, 3, 4, 0, 0, 0, 0);
        cfg_prog_cycles = 8'd6;
        run_op(2'd1, 13'h0007, 8'h0F);
        for (int i = 0; i < 4; i++)
            chk(a_cyc[i] == i + 2, "R4 early drop per bit", a_cyc[i], i + 2);
        chk(a_cyc[4] == 0 && a_cyc[7] == 0, "R2 untargeted bits isolated", a_cyc[4] + a_cyc[7], 0);
        chk(busy_n == 6 && timeout == 1'b0, "R4 ends on last completion", busy_n, 6);
        // last completion coincides with limit
        set_need(0, 0, 2, 0, 0, 0, 0, 0);
        cfg_prog_cycles = 8'd3;
        run_op(2'd1, 13'h0000, 8'h04);
        chk(a_cyc[2] == 3 && timeout == 1'b0, "R4 completion on final cycle", {a_cyc[2], timeout}, 3);
    endtask

    task automatic t_erase;
        set_need(0, 0, 0, 0, 1, 0, 0, 0);
        cfg_erase_cycles = 8'd3;
        run_op(2'd2, 13'h0A3C, 8'h30);
        chk(s_cyc[4] == 2 && s_cyc[5] == 3, "R3 erase drive per bit", s_cyc[4] * 16 + s_cyc[5], 8'h23);
        chk(a_cyc[4] == 0 && a_cyc[5] == 0 && s_cyc[0] == 0, "R3 anode held low", a_cyc[5], 0);
        chk(lvl_bad == 0 && row_bad == 0, "R3 erase level", lvl_bad, 0);
        chk(timeout == 1'b1 && busy_n == 4, "R7 erase timeout", busy_n, 4);
        chk(fin_bad == 0, "R8 source lines grounded after erase", fin_bad, 0);
        set_need(0, 0, 0, 0, 0, 0, 0, 0);
        cfg_erase_cycles = 8'd0;
        run_op(2'd2, 13'h0001, 8'h01);
        chk(s_cyc[0] == 1 && timeout == 1'b1, "R7 zero count acts as one", s_cyc[0], 1);
    endtask

    task automatic t_busy_ignore;
        set_need(0, 0, 0, 0, 0, 0, 0, 0);
        cfg_prog_cycles = 8'd4;
        inject_cyc = 2;
        run_op(2'd1, 13'h0011, 8'h01);
        inject_cyc = 0;
        chk(a_cyc[0] == 4 && busy_n == 5, "R9 busy run unaffected", busy_n, 5);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!busy && source_en == 0, "R9 request while busy dropped", busy, 0);
        end
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_data = 8'hFF;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!busy && !wl_en, "R9 reserved op ignored", busy, 0);
        @(negedge clk);
        chk(!busy && !done, "R1 idle after reserved op", busy, 0);
    endtask

    task automatic t_zero_mask;
        cfg_prog_cycles = 8'd5;
        run_op(2'd1, 13'h0003, 8'h00);
        chk(busy_n == 2, "R10 one write cycle", busy_n, 2);
        chk(timeout == 1'b0, "R10 no timeout", timeout, 0);
        begin
            int sum = 0;
            for (int i = 0; i < 8; i++) sum += a_cyc[i] + s_cyc[i];
            chk(sum == 0, "R10 no line driven", sum, 0);
        end
    endtask

    initial begin
        set_need(0, 0, 0, 0, 0, 0, 0, 0);
        inject_cyc = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read();
        t_prog_timeout();
        t_prog_early();
        t_erase();
        t_busy_ignore();
        t_zero_mask();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule